// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Controller

This block follows the device-wide power state of a DDR SDRAM from the clock-enable level seen at the previous rising edge and at the current one, the command on the control pins, and an all-banks-idle hint that per-bank tracking logic outside this block supplies. A falling clock enable can mean three things. With every bank idle and an auto-refresh pattern on the pins it starts self-refresh. With every bank idle and a deselect or no-operation it starts power-down. With any bank open it suspends the clock. The controller picks the right one, and it raises a one-cycle flag when the pins carry a pattern that is not allowed at that transition.

The block drives a registered internal clock enable that is low for the cycle after a low clock enable is sampled. It also drives a three-bit state code and a command-accept qualifier. After self-refresh is left, a recovery window of `TRC` cycles holds off new commands. A down-counter times this window before the controller returns to normal operation.

Top module: `cke_power_ctrl`

## Requirements
- R1: While reset is asserted and at the first edge after its release, the state code is 0 (normal), the internal clock enable is 1, the illegal flag is 0 and cmd_ok is 1.
- R2: Command encoding is as follows: cs_n high is deselect. With cs_n low, ras_n/cas_n/we_n = 1/1/1 is no-operation and 0/0/1 is auto-refresh. Any other low-cs_n pattern is another command. In normal state, clock enable 1 at the previous edge and 0 now, with all banks idle and auto-refresh on the pins, give state code 1 (self-refresh) after the edge.
- R3: Under the same clock-enable fall with all banks idle and a deselect or no-operation, the state code becomes 2 (power-down).
- R4: Under the same fall with all banks idle and any other command, the illegal flag is 1 for exactly one cycle and the state code stays 0.
- R5: A clock-enable fall in normal state while any bank is not idle gives state code 3 (clock suspend), whatever the command.
- R6: Self-refresh holds for as long as clock enable stays low.
- R7: A low-to-high clock enable in self-refresh gives state code 4 (recovery). The state stays at 4 for exactly TRC cycles and then returns to 0. cmd_ok is 0 throughout.
- R8: A self-refresh exit whose pins carry neither deselect nor no-operation raises the illegal flag for one cycle and still enters recovery.
- R9: In power-down or clock suspend, a low-to-high clock enable returns the state code to 0 after that edge.
- R10: The internal clock enable equals the clock enable sampled at the most recent edge.
- R11: cmd_ok is 1 only in normal state with the internal clock enable at 1.
- R12: A clock-enable fall during recovery has no effect on the state code or on the recovery length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cke | input | 1 | Clock enable at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write enable pin |
| all_banks_idle | input | 1 | High when no bank is open |
| clk_en_int | output | 1 | Internal clock enable |
| pstate | output | 3 | State code: 0 normal, 1 self-refresh, 2 power-down, 3 suspend, 4 recovery |
| illegal | output | 1 | One-cycle flag for a disallowed pattern at a transition |
| cmd_ok | output | 1 | Commands may be accepted this cycle |

## Verification
The state code is visible directly at the ports, so a wrong transition shows in the cycle after the edge that caused it. A miscounted recovery window is different. It stays hidden until the expected return to normal, where the state code and cmd_ok change one or more cycles early or late. A lost clock-enable history shows up first on the next rising or falling clock enable, as a missed entry or exit. The bench runs a cycle-accurate model alongside the design and compares all four outputs every cycle.

// File: rtl/cke_power_pkg.sv
package cke_power_pkg;
  typedef enum logic [2:0] {
    PS_NORMAL = 3'd0,
    PS_SELF   = 3'd1,
    PS_PDOWN  = 3'd2,
    PS_SUSP   = 3'd3,
    PS_RECOV  = 3'd4
  } pstate_e;
endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode (
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic quiet,
  output logic refresh
);
  // quiet: deselect or no-operation; refresh: auto-refresh pattern
  always_comb begin
    quiet   = cs_n | (ras_n & cas_n & we_n);
    refresh = ~cs_n & ~ras_n & ~cas_n & we_n;
  end
endmodule

// File: rtl/cke_rc_timer.sv
module cke_rc_timer #(
  parameter int TRC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(TRC + 1);
  localparam logic [CW-1:0] START = CW'(TRC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (tick & (cnt_q != '0));
    cnt_d  = load ? START : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  p_load_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == START));
endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl #(
  parameter int TRC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       all_banks_idle,
  output logic       clk_en_int,
  output logic [2:0] pstate,
  output logic       illegal,
  output logic       cmd_ok
);
  import cke_power_pkg::*;

  pstate_e state_q, state_d;
  logic    cke_prev_q;
  logic    clk_en_q;
  logic    ill_q, ill_d;
  logic    quiet, refresh;
  logic    fall, rise;
  logic    rc_load, rc_tick, rc_done;

  cke_cmd_decode u_dec (
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .quiet   (quiet),
    .refresh (refresh)
  );

  cke_rc_timer #(.TRC(TRC)) u_rc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rc_load),
    .tick  (rc_tick),
    .done  (rc_done)
  );

  assign fall    = cke_prev_q & ~cke;
  assign rise    = ~cke_prev_q & cke;
  assign rc_tick = (state_q == PS_RECOV);

  always_comb begin
    state_d = state_q;
    ill_d   = 1'b0;
    rc_load = 1'b0;
    case (state_q)
      PS_NORMAL: if (fall) begin
        if (!all_banks_idle) state_d = PS_SUSP;
        else if (refresh)    state_d = PS_SELF;
        else if (quiet)      state_d = PS_PDOWN;
        else                 ill_d   = 1'b1;
      end
      PS_SELF: if (rise) begin
        state_d = PS_RECOV;
        rc_load = 1'b1;
        ill_d   = ~quiet;
      end
      PS_PDOWN, PS_SUSP: if (rise) state_d = PS_NORMAL;
      PS_RECOV: if (rc_done) state_d = PS_NORMAL;
      default: state_d = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_NORMAL;
      cke_prev_q <= 1'b1;
      clk_en_q   <= 1'b1;
      ill_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      cke_prev_q <= cke;
      clk_en_q   <= cke;
      ill_q      <= ill_d;
    end
  end

  assign clk_en_int = clk_en_q;
  assign pstate     = state_q;
  assign illegal    = ill_q;
  assign cmd_ok     = (state_q == PS_NORMAL) & clk_en_q;

  p_self_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_NORMAL && fall && all_banks_idle && refresh) |=> (state_q == PS_SELF));
  p_pdown_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_NORMAL && fall && all_banks_idle && quiet) |=> (state_q == PS_PDOWN));
  p_illegal_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |=> !ill_q);
  p_suspend_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_NORMAL && fall && !all_banks_idle) |=> (state_q == PS_SUSP));
  p_self_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SELF && !cke) |=> (state_q == PS_SELF));
  p_recov_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RECOV && !rc_done) |=> (state_q == PS_RECOV));
  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_PDOWN || state_q == PS_SUSP) && rise) |=> (state_q == PS_NORMAL));
endmodule

// File: tb/tb_cke_power_ctrl.sv
module tb_cke_power_ctrl;
  localparam int TRC = 8;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, idle;
  logic clk_en_int, illegal, cmd_ok;
  logic [2:0] pstate;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  // reference model
  int   m_state, m_rem;
  logic m_prev, m_clken, m_ill;

  always #5 clk = ~clk;

  cke_power_ctrl #(.TRC(TRC)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .all_banks_idle(idle),
    .clk_en_int(clk_en_int), .pstate(pstate), .illegal(illegal), .cmd_ok(cmd_ok)
  );

  function automatic bit is_quiet(logic cs, logic r, logic c, logic w);
    return cs || (r && c && w);
  endfunction
  function automatic bit is_refa(logic cs, logic r, logic c, logic w);
    return !cs && !r && !c && w;
  endfunction

  task automatic compare(input string tag);
    logic exp_ok;
    exp_ok = (m_state == 0) && m_clken;
    n_chk++;
    if (pstate !== 3'(m_state) || clk_en_int !== m_clken || illegal !== m_ill || cmd_ok !== exp_ok) begin
      n_fail++;
      $display("FAIL %s: state/clken/ill/ok actual %0d/%b/%b/%b expected %0d/%b/%b/%b",
               tag, pstate, clk_en_int, illegal, cmd_ok, m_state, m_clken, m_ill, exp_ok);
    end
  endtask

  task automatic step(input logic k, input logic cs, input logic r, input logic c,
                      input logic w, input logic id, input string tag);
    int   ns, nr;
    logic nill, f, ri;
    cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; idle = id;
    f = m_prev && !k;
    ri = !m_prev && k;
    ns = m_state; nr = m_rem; nill = 1'b0;
    case (m_state)
      0: if (f) begin
        if (!id) ns = 3;
        else if (is_refa(cs, r, c, w)) ns = 1;
        else if (is_quiet(cs, r, c, w)) ns = 2;
        else nill = 1'b1;
      end
      1: if (ri) begin ns = 4; nr = TRC; nill = !is_quiet(cs, r, c, w); end
      2, 3: if (ri) ns = 0;
      4: begin nr = m_rem - 1; if (nr == 0) ns = 0; end
      default: ns = 0;
    endcase
    @(posedge clk);
    m_state = ns; m_rem = nr; m_ill = nill; m_prev = k; m_clken = k;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; idle = 1'b1;
    m_state = 0; m_rem = 0; m_prev = 1'b1; m_clken = 1'b1; m_ill = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    step(1, 1, 1, 1, 1, 1, "R1 after release");

    // power-down entry, hold, exit
    step(0, 0, 1, 1, 1, 1, "R3 power-down entry on NOP");
    step(0, 1, 0, 1, 0, 1, "R3 power-down held");
    step(1, 1, 1, 1, 1, 1, "R9 power-down exit");
    step(1, 1, 1, 1, 1, 1, "R11 normal accept");
    step(0, 1, 1, 1, 1, 1, "R3 power-down entry on deselect");
    step(1, 0, 0, 1, 1, 0, "R9 power-down exit any pins");

    // clock suspend
    step(0, 0, 1, 0, 1, 0, "R5 suspend on READ with open bank");
    step(0, 0, 0, 0, 1, 0, "R10 clock enable low in suspend");
    step(1, 1, 1, 1, 1, 0, "R9 suspend exit");

    // illegal fall
    step(0, 0, 0, 1, 1, 1, "R4 illegal ACT at idle fall");
    step(0, 0, 1, 1, 1, 1, "R4 flag cleared, stays normal");
    step(1, 1, 1, 1, 1, 1, "R11 normal after illegal");

    // self-refresh, clean exit
    step(0, 0, 0, 0, 1, 1, "R2 self-refresh entry");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 1, "R6 self-refresh held");
    step(1, 1, 1, 1, 1, 1, "R7 exit to recovery");
    for (int i = 0; i < TRC; i++) step(1, 0, 0, 1, 1, 1, "R7 recovery window");
    step(1, 1, 1, 1, 1, 1, "R7 back in normal");

    // self-refresh, illegal exit, fall during recovery
    step(0, 0, 0, 0, 1, 1, "R2 self-refresh entry again");
    step(1, 0, 1, 1, 0, 1, "R8 illegal exit pattern");
    step(0, 0, 0, 0, 1, 1, "R12 fall in recovery ignored");
    step(0, 1, 1, 1, 1, 1, "R12 low in recovery");
    step(1, 1, 1, 1, 1, 1, "R12 rise in recovery");
    for (int i = 0; i < TRC; i++) step(1, 1, 1, 1, 1, 1, "R7 recovery completes");

    // constrained random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      logic k, cs, id;
      logic [2:0] p;
      k  = ($urandom % 4 == 0) ? !cke : cke;
      cs = ($urandom % 3 == 0);
      p  = 3'($urandom % 8);
      if ($urandom % 3 == 0) p = 3'b001;
      id = ($urandom % 4 != 0);
      step(k, cs, p[2], p[1], p[0], id, "R2-random mix");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule